// File: doc/BRIEF.md
# Variable-Length Instruction Splitter

This block sits between an instruction fetch buffer and the decode stage. Fetch hands it beats of up to four bytes in little-endian order, and the block hands back one whole instruction per cycle. An instruction is one, two or three bytes long. Its size is read from the few lowest bits of its first byte alone, so the block never has to look at later bytes to find an instruction boundary.

Bytes that do not yet form a whole instruction wait in an internal byte queue. An instruction that straddles two fetch beats is therefore presented in one piece. Both sides of the block use a ready/valid handshake. A flush input drops everything queued, so that fetch can resume at a redirected address. A first byte whose prefix selects no legal size is passed on as a one-byte item with an illegal flag, and the stream stays in step.

Internally, a small controller keeps a registered state that classifies the queue as it will be after the current edge. There are three states:
- `ST_IDLE`: the queue is empty.
- `ST_GATHER`: the queue holds some bytes, but fewer than the leading instruction needs.
- `ST_ISSUE`: the leading instruction is complete.

The transitions are:
- `IDLE->GATHER`: a beat arrives that holds only part of an instruction.
- `IDLE->ISSUE` and `GATHER->ISSUE`: the missing bytes arrive.
- `ISSUE->ISSUE`: after a pop, another complete instruction follows.
- `ISSUE->GATHER`: after a pop, only a fragment is left.
- `ISSUE->IDLE`: after a pop, the queue is drained.
- `any->IDLE`: flush.

Top module: `ilen_split`

## Requirements
- R1: A first byte with bit 0 equal to 0 gives a one-byte instruction: `out_len`=1, `out_insn` equals that byte zero-extended, and `out_illegal`=0.
- R2: A first byte with bits [1:0]=01 gives a two-byte instruction: `out_len`=2, and `out_insn[23:16]`=0.
- R3: A first byte with bits [2:0]=011 gives a three-byte instruction: `out_len`=3.
- R4: A first byte with bits [2:0]=111 is consumed alone. `out_len`=1 and `out_illegal`=1, and the next byte starts a new instruction.
- R5: Lane k of a beat is `in_data[8k+7:8k]`, and a lower lane comes earlier in the stream. Within an instruction, the first byte appears in `out_insn[7:0]`, the second in `[15:8]` and the third in `[23:16]`.
- R6: `out_valid` stays low until every byte of the leading instruction has been accepted. An instruction whose bytes arrive over several beats is emitted whole.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_insn` and `out_len` hold their values.
- R8: While `flush` is high, `out_valid` and `in_ready` are low. In the cycle after `flush`, the queue is empty, and decoding restarts from the next accepted beat.
- R9: `in_ready` is low when the queue holds more than DEPTH-LANES bytes. No byte is ever dropped or repeated.
- R10: `in_mask` marks the valid lanes and must be packed from lane 0. Only marked lanes are queued, and a beat with mask 0 adds nothing.
- R11: After reset, `out_valid`=0 and `in_ready`=1.
- R12: At most one instruction is emitted per cycle, and a queue of complete instructions drains at one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drops all queued bytes (branch redirect) |
| in_valid | input | 1 | Fetch beat present |
| in_ready | output | 1 | Block can take a full beat |
| in_data | input | 32 | Beat bytes, lane 0 in bits 7:0 |
| in_mask | input | 4 | Valid lanes, packed from lane 0 |
| out_valid | output | 1 | Complete instruction presented |
| out_ready | input | 1 | Decode accepts the instruction |
| out_insn | output | 24 | Instruction, zero above its length |
| out_len | output | 2 | Length in bytes: 1, 2 or 3 |
| out_illegal | output | 1 | First byte had an undefined prefix |

## Verification
The assertions take for granted that `in_mask` is packed from lane 0 whenever `in_valid` is high. The queue's insertion logic counts lanes rather than compacting them, so a gapped mask would corrupt the stream. The bench therefore builds every beat with masks of the form 0000, 0001, 0011, 0111 or 1111. It applies inputs on the falling edge, so that the handshakes seen at the rising edge are settled. Backpressure on `out_ready` is varied freely, because the hold property has to cover any pattern of stalls.

// File: rtl/ilen_pkg.sv
package ilen_pkg;

    // Queue classification held by the controller
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_ISSUE  = 2'd2
    } split_state_t;

    // Widest instruction in bytes
    localparam int unsigned MAX_BYTES = 3;

endpackage

// File: rtl/ilen_prefix.sv
// Size decode from the first byte of an instruction.
module ilen_prefix (
    input  logic [7:0] lead,
    output logic [1:0] size,
    output logic       bad
);
    always_comb begin
        bad  = 1'b0;
        size = 2'd1;
        unique casez (lead[2:0])
            3'b??0: size = 2'd1;
            3'b?01: size = 2'd2;
            3'b011: size = 2'd3;
            default: begin
                // 111: undefined, swallowed as a single byte
                size = 2'd1;
                bad  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ilen_queue.sv
// Byte queue with the oldest byte at slot 0. A pop shifts it down,
// and a push appends behind whatever survives the pop.
module ilen_queue #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LANES = 4,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               push,
    input  logic [LANES*8-1:0] wr_bytes,
    input  logic [CW-1:0]      wr_cnt,
    input  logic               pop,
    input  logic [1:0]         pop_cnt,
    output logic [CW-1:0]      fill_q,
    output logic [CW-1:0]      fill_d,
    output logic [7:0]         lead_d,
    output logic [23:0]        window
);
    localparam int unsigned IW = $clog2(DEPTH);
    localparam int unsigned LW = $clog2(LANES);

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];
    logic [7:0] lane_b [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_b[g] = wr_bytes[g*8 +: 8];
    end

    always_comb begin
        int shift;
        int keep;
        int src;
        int lane;
        shift = pop ? int'(pop_cnt) : 0;
        keep  = int'(fill_q) - shift;
        for (int i = 0; i < int'(DEPTH); i++) begin
            src      = i + shift;
            lane     = i - keep;
            mem_d[i] = 8'h00;
            if (clear) begin
                mem_d[i] = 8'h00;
            end else if (i < keep && src < int'(DEPTH)) begin
                mem_d[i] = mem_q[IW'(src)];
            end else if (push && lane >= 0 && lane < int'(wr_cnt) && lane < int'(LANES)) begin
                mem_d[i] = lane_b[LW'(lane)];
            end
        end
        if (clear) begin
            fill_d = '0;
        end else begin
            fill_d = CW'(keep + (push ? int'(wr_cnt) : 0));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
            for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= 8'h00;
        end else begin
            fill_q <= fill_d;
            for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= mem_d[i];
        end
    end

    assign lead_d = mem_d[0];
    assign window = {mem_q[2], mem_q[1], mem_q[0]};

    // Queue never holds more than it has room for
    assert_fill_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CW'(DEPTH))
        else $error("queue fill above depth");

    // A pop only takes bytes that are actually present
    assert_pop_whole_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (CW'(pop_cnt) <= fill_q))
        else $error("pop larger than queue fill");
endmodule

// File: rtl/ilen_ctrl.sv
// Classifies the queue for the next cycle and drives the handshakes.
module ilen_ctrl
    import ilen_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LANES = 4,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          out_ready,
    input  logic [CW-1:0] fill_q,
    input  logic [CW-1:0] fill_d,
    input  logic [7:0]    lead_d,
    output logic          out_valid,
    output logic          in_ready,
    output logic          pop,
    output logic [1:0]    size_q,
    output logic          bad_q
);
    split_state_t state_q, state_d;
    logic [1:0]   size_d;
    logic         bad_d;

    ilen_prefix u_next_prefix (
        .lead (lead_d),
        .size (size_d),
        .bad  (bad_d)
    );

    always_comb begin
        if (fill_d == '0) begin
            state_d = ST_IDLE;
        end else if (fill_d >= CW'(size_d)) begin
            state_d = ST_ISSUE;
        end else begin
            state_d = ST_GATHER;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            size_q  <= 2'd1;
            bad_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            size_q  <= size_d;
            bad_q   <= bad_d;
        end
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   out_valid = 1'b0;
            ST_GATHER: out_valid = 1'b0;
            ST_ISSUE:  out_valid = !flush;
            default:   out_valid = 1'b0;
        endcase
        pop      = out_valid && out_ready;
        in_ready = !flush && (fill_q <= CW'(DEPTH - LANES));
    end

    // The leading instruction is whole whenever it is offered
    assert_issue_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (fill_q >= CW'(size_q)))
        else $error("instruction offered before all bytes present");

    // Room for a full beat whenever a beat is taken
    assert_room_for_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (fill_q + CW'(LANES) <= CW'(DEPTH)))
        else $error("beat accepted without room");
endmodule

// File: rtl/ilen_split.sv
module ilen_split
    import ilen_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [LANES*8-1:0] in_data,
    input  logic [LANES-1:0]   in_mask,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [23:0]        out_insn,
    output logic [1:0]         out_len,
    output logic               out_illegal
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0] wr_cnt;
    logic [CW-1:0] fill_q;
    logic [CW-1:0] fill_d;
    logic [7:0]    lead_d;
    logic [23:0]   window;
    logic [1:0]    size_q;
    logic          bad_q;
    logic          pop;
    logic          push;

    always_comb begin
        wr_cnt = '0;
        for (int i = 0; i < int'(LANES); i++) wr_cnt = wr_cnt + CW'(in_mask[i]);
    end

    assign push = in_valid && in_ready;

    ilen_queue #(.DEPTH(DEPTH), .LANES(LANES), .CW(CW)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (flush),
        .push     (push),
        .wr_bytes (in_data),
        .wr_cnt   (wr_cnt),
        .pop      (pop),
        .pop_cnt  (size_q),
        .fill_q   (fill_q),
        .fill_d   (fill_d),
        .lead_d   (lead_d),
        .window   (window)
    );

    ilen_ctrl #(.DEPTH(DEPTH), .LANES(LANES), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .out_ready (out_ready),
        .fill_q    (fill_q),
        .fill_d    (fill_d),
        .lead_d    (lead_d),
        .out_valid (out_valid),
        .in_ready  (in_ready),
        .pop       (pop),
        .size_q    (size_q),
        .bad_q     (bad_q)
    );

    // Zero-fill the word above the instruction's length
    for (genvar k = 0; k < int'(MAX_BYTES); k++) begin : g_fill
        assign out_insn[k*8 +: 8] = (int'(size_q) > k) ? window[k*8 +: 8] : 8'h00;
    end

    assign out_len     = size_q;
    assign out_illegal = bad_q && out_valid;

    assert_one_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_insn[0]) |-> (out_len == 2'd1 && !out_illegal))
        else $error("bit0=0 prefix not one byte");

    assert_two_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_insn[1:0] == 2'b01) |-> (out_len == 2'd2 && out_insn[23:16] == 8'h00))
        else $error("01 prefix not two bytes");

    assert_three_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_insn[2:0] == 3'b011) |-> (out_len == 2'd3))
        else $error("011 prefix not three bytes");

    assert_bad_prefix_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_insn[2:0] == 3'b111) |-> (out_len == 2'd1 && out_illegal))
        else $error("111 prefix not flagged single byte");

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (flush || (out_valid && $stable(out_insn) && $stable(out_len))))
        else $error("stalled output changed");

    assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid)
        else $error("output valid after flush");

    assert_mask_packed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (((in_mask + 1'b1) & in_mask) == '0))
        else $error("lane mask not packed from lane 0");
endmodule

// File: tb/test_ilen_split.sv
`timescale 1ns/1ps
module test_ilen_split;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = 32'h0;
    logic [3:0]  in_mask = 4'h0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_insn;
    logic [1:0]  out_len;
    logic        out_illegal;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ilen_split i_ilen_split (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_mask(in_mask),
        .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
        .out_len(out_len), .out_illegal(out_illegal)
    );

    // Beats: {mask, data}; lane 0 is data[7:0]
    localparam int N_BEAT = 8;
    localparam logic [35:0] BEATS [N_BEAT] = '{
        {4'b1111, 32'h0BAA3510},
        {4'b0011, 32'h0000D5C4},
        {4'b1111, 32'h11032207},
        {4'b0001, 32'h00000099},
        {4'b0000, 32'hFFFFFFFF},
        {4'b0111, 32'h000FEE01},
        {4'b1111, 32'h05700DFE},
        {4'b0001, 32'h00000066}
    };
    // Expected: {illegal, len, insn}
    localparam int N_OUT = 11;
    localparam logic [26:0] EXPS [N_OUT] = '{
        {1'b0, 2'd1, 24'h000010},
        {1'b0, 2'd2, 24'h00AA35},
        {1'b0, 2'd3, 24'hD5C40B},
        {1'b1, 2'd1, 24'h000007},
        {1'b0, 2'd1, 24'h000022},
        {1'b0, 2'd3, 24'h991103},
        {1'b0, 2'd2, 24'h00EE01},
        {1'b1, 2'd1, 24'h00000F},
        {1'b0, 2'd1, 24'h0000FE},
        {1'b0, 2'd2, 24'h00700D},
        {1'b0, 2'd2, 24'h006605}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Offer one beat at a falling edge, hold it across one rising edge
    task automatic push1(input logic [3:0] m, input logic [31:0] d);
        chk(in_ready == 1'b1, "R9 ready before beat", {31'h0, in_ready}, 32'h1);
        in_valid = 1'b1; in_mask = m; in_data = d;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_mask = 4'h0;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R11 out_valid in reset", {31'h0, out_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(out_valid == 1'b0, "R11 out_valid after reset", {31'h0, out_valid}, 32'h0);
        chk(in_ready == 1'b1, "R11 in_ready after reset", {31'h0, in_ready}, 32'h1);

        // Table walk: pass 0 free-flowing, pass 1 with stalls (R1-R5, R7, R10)
        for (int pass = 0; pass < 2; pass++) begin
            int bi;
            int oi;
            int cyc;
            bit held;
            logic [23:0] held_insn;
            bi = 0; oi = 0; cyc = 0; held = 1'b0; held_insn = '0;
            while (oi < N_OUT && cyc < 400) begin
                @(negedge clk);
                if (held)
                    chk(out_valid && out_insn == held_insn, "R7 hold under stall",
                        {7'h0, out_valid, out_insn}, {8'h01, held_insn});
                in_valid = (bi < N_BEAT);
                {in_mask, in_data} = (bi < N_BEAT) ? BEATS[bi] : 36'h0;
                out_ready = (pass == 0) ? 1'b1 : ((cyc % 3) != 0);
                #1;
                if (out_valid && out_ready) begin
                    chk({out_illegal, out_len, out_insn} == EXPS[oi], "R1 R2 R3 R4 R5 R10 stream item",
                        {5'h0, out_illegal, out_len, out_insn}, {5'h0, EXPS[oi]});
                    oi++;
                end
                if (in_valid && in_ready) bi++;
                held = out_valid && !out_ready;
                held_insn = out_insn;
                cyc++;
            end
            chk(oi == N_OUT, "R12 all items emitted", oi, N_OUT);
            in_valid = 1'b0; in_mask = 4'h0;
        end

        // R6: three-byte instruction delivered one byte per beat
        @(negedge clk); #1;
        out_ready = 1'b1;
        push1(4'b0001, 32'h0000000B);
        chk(out_valid == 1'b0, "R6 one of three", {31'h0, out_valid}, 32'h0);
        push1(4'b0001, 32'h00000044);
        chk(out_valid == 1'b0, "R6 two of three", {31'h0, out_valid}, 32'h0);
        push1(4'b0001, 32'h00000055);
        chk(out_valid && out_insn == 24'h55440B && out_len == 2'd3, "R6 whole instruction",
            {5'h0, out_valid, out_len, out_insn}, {5'h0, 1'b1, 2'd3, 24'h55440B});
        tick();
        chk(out_valid == 1'b0, "R6 drained", {31'h0, out_valid}, 32'h0);

        // R8: flush a fragment, with a beat offered during the flush
        out_ready = 1'b0;
        push1(4'b0011, 32'h0000C40B);
        flush = 1'b1; in_valid = 1'b1; in_mask = 4'b1111; in_data = 32'h10101010;
        #1;
        chk(in_ready == 1'b0, "R8 in_ready low in flush", {31'h0, in_ready}, 32'h0);
        @(posedge clk); @(negedge clk);
        flush = 1'b0; in_valid = 1'b0; in_mask = 4'h0;
        #1;
        chk(out_valid == 1'b0, "R8 empty after flush", {31'h0, out_valid}, 32'h0);
        out_ready = 1'b1;
        push1(4'b0001, 32'h00000022);
        chk(out_valid && out_insn == 24'h000022 && out_len == 2'd1, "R8 restart after flush",
            {5'h0, out_valid, out_len, out_insn}, {5'h0, 1'b1, 2'd1, 24'h000022});
        tick();

        // R8: flush drops a complete instruction in the same cycle
        out_ready = 1'b0;
        push1(4'b0001, 32'h00000010);
        chk(out_valid == 1'b1, "R8 ready before flush", {31'h0, out_valid}, 32'h1);
        flush = 1'b1; #1;
        chk(out_valid == 1'b0, "R8 valid dropped during flush", {31'h0, out_valid}, 32'h0);
        @(posedge clk); @(negedge clk);
        flush = 1'b0; #1;
        chk(out_valid == 1'b0, "R8 nothing left after flush", {31'h0, out_valid}, 32'h0);

        // R9: fill the queue under a stall, then drain at one per cycle (R12)
        push1(4'b1111, 32'h10203040);
        push1(4'b1111, 32'h50607080);
        chk(in_ready == 1'b0, "R9 ready low when full", {31'h0, in_ready}, 32'h0);
        out_ready = 1'b1;
        #1;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] e;
            e = (k < 4) ? 8'(8'h40 - 8'(k * 16)) : 8'(8'h80 - 8'((k - 4) * 16));
            chk(out_valid && out_insn == {16'h0, e}, "R9 R12 drain order",
                {7'h0, out_valid, out_insn}, {8'h01, 16'h0, e});
            tick();
        end
        chk(out_valid == 1'b0, "R12 empty after drain", {31'h0, out_valid}, 32'h0);
        chk(in_ready == 1'b1, "R9 ready after drain", {31'h0, in_ready}, 32'h1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule